// File: doc/BRIEF.md
# Sample-Rate Soft Reset Sequencer

This block turns a software-written run/reset control bit into the internal reset of a two-channel audio datapath. Entry into reset and release from reset are both timed in sample periods. The control bit is sampled only on sample-rate (fs) strobes. A fixed strobe count then follows. Entry takes three strobes after the sampling strobe, and release takes two. The internal reset therefore changes 3 to 4 sample periods after a write to 0, and 2 to 3 sample periods after a write to 1, depending on where the write falls within the sample period.

While the internal reset is active, the block raises a select that swaps the datapath input for zero data. It also drives one zero-detect flag pin for each channel. The flags turn active in the same cycle that the control bit goes to 0. They stay active through the reset and drop two strobes after the internal reset is released. Outside that window each flag follows the datapath's own zero indication, either per channel or combined. An active-low option and an enable are applied to the flags at the pins. Control registers and the clock divider sit outside the block, and the block never resets them.

Top module: `fs_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dp_rst` and `zero_sel` are 1 and both flag pins show the active level. The next two strobes that follow with `run_req` = 1 release the reset.
- R2: When `run_req` is 0 at a strobe edge (the sampling strobe), `dp_rst` stays 0 through the next two strobe edges and becomes 1 at the third.
- R3: When `dp_rst` is 1 and the minimum length of R4 is met, a sampled `run_req` of 1 clears `dp_rst` at the second strobe edge after the sampling strobe.
- R4: A reset pulse always lasts at least three strobe periods. A release that would come sooner waits until the third strobe edge after assertion.
- R5: If `run_req` returns to 1 and is sampled before the entry count completes, no reset pulse is produced.
- R6: `zero_sel` is 1 exactly while `dp_rst` is 1.
- R7: With `zd_en` = 1, both flag pins turn active in the same cycle that `run_req` drops to 0, without waiting for a strobe or for `dp_rst`.
- R8: The flags stay active while `dp_rst` is 1. They return to the follow behaviour at the second strobe edge after `dp_rst` falls, or, when an entry was cancelled, at the second strobe edge after the 1 is sampled.
- R9: Outside the forced window, with `zd_mode` = 0, `flag_l` follows `zero_l_in` and `flag_r` follows `zero_r_in` in the same cycle.
- R10: With `zd_mode` = 1, both flags show the AND of `zero_l_in` and `zero_r_in`.
- R11: `zd_pol` = 1 inverts both pins (active level 0). `zd_pol` = 0 makes them active high.
- R12: With `zd_en` = 0, both pins hold the inactive level (equal to `zd_pol`), even during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| run_req | input | 1 | Control bit: 1 = run, 0 = hold datapath in reset |
| zd_en | input | 1 | Zero-detect flag enable |
| zd_pol | input | 1 | Flag polarity: 1 = active low |
| zd_mode | input | 1 | 0 = per-channel flags, 1 = combined AND |
| zero_l_in | input | 1 | Left-channel zero indication from datapath |
| zero_r_in | input | 1 | Right-channel zero indication from datapath |
| dp_rst | output | 1 | Internal datapath reset, active high |
| zero_sel | output | 1 | Replace datapath input with zero data |
| flag_l | output | 1 | Left zero-detect flag pin |
| flag_r | output | 1 | Right zero-detect flag pin |

## Verification
The reset timing is checked in strobe units. Each write to `run_req` is placed one time unit after a strobe edge, so the next strobe edge is the sampling one. After every later strobe edge the bench samples `dp_rst` and `zero_sel`, expecting the change at sampling-plus-three for entry and sampling-plus-two for release. For a release that is held back by the minimum pulse length, the change is expected one edge later. Flag outputs are combinational from the force state and the zero inputs, so they are checked one time unit after the driving input changes. The end of the forced window is checked at the first and second strobe edges after release.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef struct packed {
        logic en;
        logic pol;
        logic mode;
    } zd_cfg_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_gate.sv
module fsr_gate #(
    parameter int unsigned ENTRY_LAT = 3,
    parameter int unsigned EXIT_LAT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_tick,
    input  logic run_req,
    output logic dp_rst,
    output logic req_s
);
    import fsr_pkg::*;

    localparam int unsigned MAXL  = max2(ENTRY_LAT, EXIT_LAT);
    localparam int unsigned CNT_W = $clog2(MAXL + 1);
    localparam logic [CNT_W-1:0] ENTRY_C = CNT_W'(ENTRY_LAT);
    localparam logic [CNT_W-1:0] EXIT_C  = CNT_W'(EXIT_LAT);
    localparam logic [CNT_W-1:0] HOLD_C  = CNT_W'(ENTRY_LAT - 1);

    typedef struct packed {
        logic             req;
        logic             rst;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic             pend;
    logic             min_ok;
    logic [CNT_W-1:0] lat;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        st_d   = st_q;
        pend   = (st_q.req == st_q.rst);
        lat    = st_q.rst ? EXIT_C : ENTRY_C;
        min_ok = !st_q.rst || (st_q.hold >= HOLD_C);
        cnt_nx = (st_q.cnt >= lat) ? lat : st_q.cnt + 1'b1;
        if (fs_tick) begin
            st_d.req = run_req;
            if (st_q.rst && (st_q.hold < HOLD_C)) begin
                st_d.hold = st_q.hold + 1'b1;
            end
            if (pend) begin
                if ((cnt_nx >= lat) && min_ok) begin
                    st_d.rst  = !st_q.rst;
                    st_d.cnt  = '0;
                    st_d.hold = '0;
                end else begin
                    st_d.cnt = cnt_nx;
                end
            end
        end
        if (!pend) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req  <= 1'b0;
            st_q.rst  <= 1'b1;
            st_q.cnt  <= '0;
            st_q.hold <= HOLD_C;
        end else begin
            st_q <= st_d;
        end
    end

    assign dp_rst = st_q.rst;
    assign req_s  = st_q.req;

    AST_ENTRY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rst) |-> $past(fs_tick)); // R2
    AST_EXIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rst) |-> $past(st_q.req)); // R3
    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rst) |-> ($past(st_q.hold) == HOLD_C)); // R4

endmodule

// File: rtl/fsr_flag_hold.sv
module fsr_flag_hold #(
    parameter int unsigned TAIL_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_tick,
    input  logic run_req,
    input  logic req_s,
    input  logic dp_rst,
    output logic force_act
);
    localparam int unsigned TW = $clog2(TAIL_LAT + 1);
    localparam logic [TW-1:0] TAIL_C = TW'(TAIL_LAT);

    typedef struct packed {
        logic          frc;
        logic [TW-1:0] tail;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     settled;

    always_comb begin
        st_d    = st_q;
        settled = run_req && req_s && !dp_rst;
        if (!run_req) begin
            st_d.frc  = 1'b1;
            st_d.tail = '0;
        end else if (st_q.frc && settled) begin
            if (fs_tick) begin
                if ((st_q.tail + 1'b1) >= TAIL_C) begin
                    st_d.frc  = 1'b0;
                    st_d.tail = '0;
                end else begin
                    st_d.tail = st_q.tail + 1'b1;
                end
            end
        end else begin
            st_d.tail = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frc  <= 1'b1;
            st_q.tail <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign force_act = st_q.frc | ~run_req;

    AST_FORCE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> st_q.frc); // R7

endmodule

// File: rtl/fsr_flag_out.sv
module fsr_flag_out
    import fsr_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  zd_cfg_t        cfg,
    input  logic           force_act,
    input  logic [NCH-1:0] zin,
    output logic [NCH-1:0] pin
);
    logic both;
    assign both = &zin;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic act;
        assign act    = force_act | (cfg.mode ? both : zin[c]);
        assign pin[c] = cfg.en ? (act ^ cfg.pol) : cfg.pol;
    end

    AST_MODE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.mode) |-> (pin[0] == pin[NCH-1])); // R10

endmodule

// File: rtl/fs_reset_sequencer.sv
module fs_reset_sequencer #(
    parameter int unsigned ENTRY_LAT = 3,
    parameter int unsigned EXIT_LAT  = 2,
    parameter int unsigned TAIL_LAT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_tick,
    input  logic run_req,
    input  logic zd_en,
    input  logic zd_pol,
    input  logic zd_mode,
    input  logic zero_l_in,
    input  logic zero_r_in,
    output logic dp_rst,
    output logic zero_sel,
    output logic flag_l,
    output logic flag_r
);
    import fsr_pkg::*;

    logic    rst_int;
    logic    req_s;
    logic    force_act;
    zd_cfg_t cfg;
    logic [1:0] pins;

    assign cfg = '{en: zd_en, pol: zd_pol, mode: zd_mode};

    fsr_gate #(.ENTRY_LAT(ENTRY_LAT), .EXIT_LAT(EXIT_LAT)) u_gate (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .run_req(run_req),
        .dp_rst(rst_int), .req_s(req_s)
    );

    fsr_flag_hold #(.TAIL_LAT(TAIL_LAT)) u_hold (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .run_req(run_req),
        .req_s(req_s), .dp_rst(rst_int), .force_act(force_act)
    );

    fsr_flag_out #(.NCH(2)) u_out (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .force_act(force_act),
        .zin({zero_r_in, zero_l_in}), .pin(pins)
    );

    assign dp_rst   = rst_int;
    assign zero_sel = rst_int;
    assign flag_l   = pins[0];
    assign flag_r   = pins[1];

    AST_FLAG_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_int && zd_en) |-> ((flag_l == ~zd_pol) && (flag_r == ~zd_pol))); // R8

endmodule

// File: tb/fs_reset_sequencer_tb.sv
module fs_reset_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FS_DIV     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs_tick = 1'b0;
    logic run_req = 1'b1;
    logic zd_en = 1'b1, zd_pol = 1'b0, zd_mode = 1'b0;
    logic zero_l_in = 1'b0, zero_r_in = 1'b0;
    logic dp_rst, zero_sel, flag_l, flag_r;
    int   fs_cnt = 0;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        fs_cnt  <= (fs_cnt == FS_DIV-1) ? 0 : fs_cnt + 1;
        fs_tick <= (fs_cnt == FS_DIV-2);
    end

    fs_reset_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .run_req(run_req),
        .zd_en(zd_en), .zd_pol(zd_pol), .zd_mode(zd_mode),
        .zero_l_in(zero_l_in), .zero_r_in(zero_r_in),
        .dp_rst(dp_rst), .zero_sel(zero_sel), .flag_l(flag_l), .flag_r(flag_r)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_strobe();
        do @(negedge clk); while (!fs_tick);
        @(posedge clk);
        #1;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) next_strobe();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #(CLK_PERIOD*3);
        chk("R1 rst/zsel/flags in reset", {dp_rst, zero_sel, flag_l, flag_r}, 4'b1111);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", {dp_rst, zero_sel, flag_l, flag_r}, 4'b1111);
        strobes(2);
        chk("R1 still held after 2 strobes", {2'b00, dp_rst, zero_sel}, 4'b0011);
        next_strobe();
        chk("R1 released at 3rd strobe", {2'b00, dp_rst, zero_sel}, 4'b0000);
        strobes(3);
        chk("R8 flags follow after release", {2'b00, flag_l, flag_r}, 4'b0000);
    endtask

    task automatic t_entry_exit();
        next_strobe();
        run_req = 1'b0;
        #1;
        chk("R7 flags immediate", {1'b0, dp_rst, flag_l, flag_r}, 4'b0011);
        for (int i = 0; i < 3; i++) begin
            next_strobe();
            chk("R2 not yet asserted", {3'b000, dp_rst}, 4'b0000);
        end
        next_strobe();
        chk("R2 asserted at 3rd strobe", {2'b00, dp_rst, zero_sel}, 4'b0011);
        strobes(3);
        run_req = 1'b1;
        next_strobe();
        chk("R3 held at sampling strobe", {3'b000, dp_rst}, 4'b0001);
        next_strobe();
        chk("R3 held one strobe later", {3'b000, dp_rst}, 4'b0001);
        next_strobe();
        chk("R3/R6 released at 2nd strobe", {2'b00, dp_rst, zero_sel}, 4'b0000);
        chk("R8 flags still active at release", {2'b00, flag_l, flag_r}, 4'b0011);
        next_strobe();
        chk("R8 flags active 1 strobe after", {2'b00, flag_l, flag_r}, 4'b0011);
        next_strobe();
        chk("R8 flags drop 2 strobes after", {2'b00, flag_l, flag_r}, 4'b0000);
    endtask

    task automatic t_min_pulse();
        next_strobe();
        run_req = 1'b0;
        strobes(3);
        run_req = 1'b1;
        next_strobe();
        chk("R4 asserted", {3'b000, dp_rst}, 4'b0001);
        next_strobe();
        chk("R4 held A+1", {3'b000, dp_rst}, 4'b0001);
        next_strobe();
        chk("R4 held A+2 by min length", {3'b000, dp_rst}, 4'b0001);
        next_strobe();
        chk("R4 released A+3", {2'b00, dp_rst, zero_sel}, 4'b0000);
        strobes(3);
    endtask

    task automatic t_cancel();
        next_strobe();
        run_req = 1'b0;
        next_strobe();
        run_req = 1'b1;
        #1;
        chk("R5 flags active during cancel", {2'b00, flag_l, flag_r}, 4'b0011);
        for (int i = 0; i < 5; i++) begin
            next_strobe();
            chk("R5 no reset pulse", {2'b00, dp_rst, zero_sel}, 4'b0000);
        end
        chk("R8 flags released after cancel", {2'b00, flag_l, flag_r}, 4'b0000);
    endtask

    task automatic t_follow();
        @(negedge clk);
        zero_l_in = 1'b1; zero_r_in = 1'b0; #1;
        chk("R9 per-channel L", {2'b00, flag_l, flag_r}, 4'b0010);
        zero_l_in = 1'b0; zero_r_in = 1'b1; #1;
        chk("R9 per-channel R", {2'b00, flag_l, flag_r}, 4'b0001);
        zd_mode = 1'b1; zero_l_in = 1'b1; zero_r_in = 1'b0; #1;
        chk("R10 combined one zero", {2'b00, flag_l, flag_r}, 4'b0000);
        zero_r_in = 1'b1; #1;
        chk("R10 combined both zero", {2'b00, flag_l, flag_r}, 4'b0011);
        zd_mode = 1'b0; zd_pol = 1'b1; zero_r_in = 1'b0; #1;
        chk("R11 inverted", {2'b00, flag_l, flag_r}, 4'b0001);
        zd_en = 1'b0; #1;
        chk("R12 disabled pol=1", {2'b00, flag_l, flag_r}, 4'b0011);
        zd_pol = 1'b0; #1;
        chk("R12 disabled pol=0", {2'b00, flag_l, flag_r}, 4'b0000);
        zero_l_in = 1'b0;
        next_strobe();
        run_req = 1'b0;
        strobes(5);
        chk("R12 disabled during reset", {1'b0, dp_rst, flag_l, flag_r}, 4'b0100);
        run_req = 1'b1;
        strobes(8);
        zd_en = 1'b1; #1;
        chk("R12 restored after run", {1'b0, dp_rst, flag_l, flag_r}, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_entry_exit();
        t_min_pulse();
        t_cancel();
        t_follow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule